// File: doc/BRIEF.md
# Framed DDR Sample Serializer

This block turns eight parallel 10-bit conversion results into eight serial data lanes, one lane per channel. Each sample period produces a 12-slot frame on every lane: two zero pad slots, then the sample bits from the least significant bit upward. The block runs on a slot clock at twelve times the sample rate. It drives a bit clock that toggles once per slot, so data moves on both of its edges at six bit-clock periods per frame. It also drives a frame clock at the sample rate that marks where each frame starts. The eight lanes share both clocks.

A sample is captured once per frame, on the last slot, and passes through a 12-frame delay line before it reaches the lane shifters. A format select, captured at the same frame boundary, picks straight offset binary or two's complement. Two's complement is formed by inverting the most significant bit. The word on a lane stays fixed for the whole frame it occupies. The bit clock and the frame clock each have an enable, and each is held low while disabled.

Top module: `ddr_frame_ser`

## Requirements
- R1: While `rst` is high, and in the first frame after it is released, every lane outputs 0. The slot counter starts at slot 0 on the first cycle after release, with the frame clock and the bit clock high when they are enabled.
- R2: Slots 0 and 1 of every frame carry 0 on every lane. Slot 2+i carries bit i of the coded word, for i from 0 to 9.
- R3: While `bclk_en_i` is high, `bclk_o` is high in even slots and low in odd slots. It therefore toggles every slot, giving six periods per frame.
- R4: While `fclk_en_i` is high, `fclk_o` is high in slots 0 to 5 and low in slots 6 to 11. Its rising edge coincides with the first pad slot.
- R5: Lane c (`dout_o[c]`) carries channel c, taken from `smp_i[c*10 +: 10]`. All lanes share the same slot timing.
- R6: With format 0 (`fmt_i` low at the capturing boundary), the word is sent unchanged as offset binary. With format 1, bit 9 is inverted to give two's complement. The format is taken at the edge that loads the word into the lane shifter, which is the last slot of the frame before transmission.
- R7: A sample captured at the last slot of frame k is sent in frame k+13, which is 12 sample clocks after capture. Frames 1 to 12 after reset send a zero sample coded with the format in force.
- R8: `smp_i` and `fmt_i` are sampled only in slot 11. Values applied in any other slot have no effect on any lane.
- R9: While an enable is low, its clock output is held at 0. The enables have no effect on the data lanes or on the slot timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twelve times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 80 | Eight 10-bit samples; channel c at bits c*10 +: 10 |
| fmt_i | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| bclk_en_i | input | 1 | Bit clock output enable |
| fclk_en_i | input | 1 | Frame clock output enable |
| dout_o | output | 8 | Serial data lanes, one per channel |
| bclk_o | output | 1 | Bit clock, six periods per frame |
| fclk_o | output | 1 | Frame clock, high for the first half of each frame |

## Verification
The hardest situation to reach is a frame whose word has to be traced back through thirteen frame boundaries. In that frame, the sample and the format come from different boundaries, while the inputs keep changing in every slot where they should be ignored. The stimulus drives fresh random samples and formats in all non-capturing slots and switches the format from frame to frame. It starts with directed words (zero, full scale, the mid-scale pair around bit 9, a per-channel pattern) and then moves to random words. Every lane is deserialized independently and compared with a bench model that pairs the sample from frame k-13 with the format from frame k-1. The clock enables are toggled at random frame boundaries.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int unsigned DFS_NCH  = 8;   // channel lanes
    localparam int unsigned DFS_SW   = 10;  // sample width
    localparam int unsigned DFS_NPAD = 2;   // zero slots at frame start
    localparam int unsigned DFS_LAT  = 12;  // frames of pipeline delay

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } num_fmt_e;

    // MSB flip converts offset binary to two's complement
    function automatic logic msb_flip(num_fmt_e f);
        return (f == FMT_TWOS);
    endfunction

endpackage

// File: rtl/dfs_slot_timer.sv
module dfs_slot_timer #(
    parameter  int unsigned FSLOTS = 12,
    localparam int unsigned SLW    = $clog2(FSLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bclk_en_i,
    input  logic           fclk_en_i,
    output logic [SLW-1:0] slot_o,
    output logic           frame_end_o,
    output logic           bclk_o,
    output logic           fclk_o
);

    localparam logic [SLW-1:0] LAST_SLOT = SLW'(FSLOTS - 1);
    localparam logic [SLW-1:0] HALF_SLOT = SLW'(FSLOTS / 2);

    logic [SLW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST_SLOT) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SLW'(1);
        end
    end

    assign slot_o      = cnt_q;
    assign frame_end_o = (cnt_q == LAST_SLOT);
    // bit clock high in even slots: one edge per slot
    assign bclk_o      = bclk_en_i & ~cnt_q[0];
    // frame clock high across the first half of the frame
    assign fclk_o      = fclk_en_i & (cnt_q < HALF_SLOT);

endmodule

// File: rtl/dfs_delay_line.sv
module dfs_delay_line #(
    parameter int unsigned DW    = 80,
    parameter int unsigned DEPTH = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);

    logic [DW-1:0] stg_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q[i] <= '0;
                end else if (adv_i) begin
                    stg_q[i] <= d_i;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q[i] <= '0;
                end else if (adv_i) begin
                    stg_q[i] <= stg_q[i-1];
                end
            end
        end
    end

    assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/dfs_lane.sv
module dfs_lane
    import dfs_pkg::*;
#(
    parameter int unsigned SW   = 10,
    parameter int unsigned NPAD = 2,
    parameter int unsigned SLW  = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  num_fmt_e       fmt_i,
    input  logic [SW-1:0]  word_i,
    input  logic [SLW-1:0] slot_i,
    output logic           bit_o
);

    localparam int unsigned IW = $clog2(SW);

    logic [SW-1:0]  word_q;
    logic [SLW-1:0] slot_off;
    logic [IW-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= {word_i[SW-1] ^ msb_flip(fmt_i), word_i[SW-2:0]};
        end
    end

    assign slot_off = slot_i - SLW'(NPAD);
    assign idx      = IW'(slot_off);

    always_comb begin
        if (slot_i < SLW'(NPAD)) begin
            bit_o = 1'b0;
        end else begin
            bit_o = word_q[idx];
        end
    end

endmodule

// File: rtl/ddr_frame_ser.sv
module ddr_frame_ser
    import dfs_pkg::*;
#(
    parameter int unsigned NCH  = DFS_NCH,
    parameter int unsigned SW   = DFS_SW,
    parameter int unsigned NPAD = DFS_NPAD,
    parameter int unsigned LAT  = DFS_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH*SW-1:0] smp_i,
    input  logic              fmt_i,
    input  logic              bclk_en_i,
    input  logic              fclk_en_i,
    output logic [NCH-1:0]    dout_o,
    output logic              bclk_o,
    output logic              fclk_o
);

    localparam int unsigned FSLOTS = NPAD + SW;
    localparam int unsigned SLW    = $clog2(FSLOTS);
    localparam int unsigned DW     = NCH * SW;

    logic [SLW-1:0] slot;
    logic           frame_end;
    logic [DW-1:0]  line_out;
    num_fmt_e       fmt_sel;

    assign fmt_sel = num_fmt_e'(fmt_i);

    dfs_slot_timer #(.FSLOTS(FSLOTS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .bclk_en_i   (bclk_en_i),
        .fclk_en_i   (fclk_en_i),
        .slot_o      (slot),
        .frame_end_o (frame_end),
        .bclk_o      (bclk_o),
        .fclk_o      (fclk_o)
    );

    dfs_delay_line #(.DW(DW), .DEPTH(LAT)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .adv_i (frame_end),
        .d_i   (smp_i),
        .q_o   (line_out)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        dfs_lane #(.SW(SW), .NPAD(NPAD), .SLW(SLW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load_i (frame_end),
            .fmt_i  (fmt_sel),
            .word_i (line_out[c*SW +: SW]),
            .slot_i (slot),
            .bit_o  (dout_o[c])
        );
    end

endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
    parameter int unsigned NCH  = 8,
    parameter int unsigned SLW  = 4,
    parameter int unsigned NPAD = 2,
    parameter int unsigned DW   = 80
) (
    input logic           clk,
    input logic           rst,
    input logic           bclk_en_i,
    input logic           fclk_en_i,
    input logic           bclk_o,
    input logic           fclk_o,
    input logic [NCH-1:0] dout_o,
    input logic [SLW-1:0] slot,
    input logic           frame_end,
    input logic [DW-1:0]  line_out
);

    // R1: first cycle after reset starts at slot 0 with idle lanes
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot == '0 && dout_o == '0));

    // R2: pad slots are zero on every lane
    a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (slot < SLW'(NPAD)) |-> (dout_o == '0));

    // R3: bit clock changes level every slot while enabled
    a_r3_bclk_toggle: assert property (@(posedge clk) disable iff (rst)
        (bclk_en_i && $past(bclk_en_i) && !$past(rst)) |-> (bclk_o != $past(bclk_o)));

    // R4: frame clock rises on the first pad slot
    a_r4_fclk_rise_pad: assert property (@(posedge clk) disable iff (rst)
        (fclk_en_i && $past(fclk_en_i) && $rose(fclk_o)) |-> (slot == '0 && dout_o == '0));

    // R8: delay line moves only after a frame boundary
    a_r8_line_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_end)) |-> $stable(line_out));

    // R9: disabled clocks stay low
    a_r9_bclk_off: assert property (@(posedge clk) disable iff (rst)
        !bclk_en_i |-> !bclk_o);
    a_r9_fclk_off: assert property (@(posedge clk) disable iff (rst)
        !fclk_en_i |-> !fclk_o);

endmodule

bind ddr_frame_ser dfs_checker #(
    .NCH(NCH), .SLW(SLW), .NPAD(NPAD), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bclk_en_i (bclk_en_i),
    .fclk_en_i (fclk_en_i),
    .bclk_o    (bclk_o),
    .fclk_o    (fclk_o),
    .dout_o    (dout_o),
    .slot      (slot),
    .frame_end (frame_end),
    .line_out  (line_out)
);

// File: tb/tb_ddr_frame_ser.sv
module tb_ddr_frame_ser;

    localparam int NCH = 8;
    localparam int SW  = 10;
    localparam int LAT = 12;
    localparam int FS  = 12;
    localparam int NF  = 48;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic [NCH*SW-1:0] smp = '0;
    logic              fmt = 1'b0;
    logic              ben = 1'b1;
    logic              fen = 1'b1;
    logic [NCH-1:0]    dout;
    logic              bclk;
    logic              fclk;

    ddr_frame_ser dut (
        .clk       (clk),
        .rst       (rst),
        .smp_i     (smp),
        .fmt_i     (fmt),
        .bclk_en_i (ben),
        .fclk_en_i (fen),
        .dout_o    (dout),
        .bclk_o    (bclk),
        .fclk_o    (fclk)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NCH*SW-1:0] smp_hist [NF];
    logic              fmt_hist [NF];
    logic [SW-1:0]     rx       [NCH];
    logic              pad_bad  [NCH];

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] code(logic [SW-1:0] w, logic tc);
        return tc ? {~w[SW-1], w[SW-2:0]} : w;
    endfunction

    function automatic logic [SW-1:0] exp_word(int f, int ch);
        logic [NCH*SW-1:0] s;
        if (f == 0) return '0;
        s = (f - LAT - 1 >= 0) ? smp_hist[f-LAT-1] : '0;
        return code(s[ch*SW +: SW], fmt_hist[f-1]);
    endfunction

    function automatic logic [NCH*SW-1:0] gen_sample(int k);
        logic [NCH*SW-1:0] s;
        for (int ch = 0; ch < NCH; ch++) begin
            case (k)
                0:       s[ch*SW +: SW] = '0;
                1:       s[ch*SW +: SW] = '1;
                2:       s[ch*SW +: SW] = 10'h200;
                3:       s[ch*SW +: SW] = 10'h1FF;
                4:       s[ch*SW +: SW] = SW'(ch * 97 + 5);
                default: s[ch*SW +: SW] = SW'($urandom);
            endcase
        end
        return s;
    endfunction

    function automatic logic [NCH*SW-1:0] junk();
        logic [NCH*SW-1:0] s;
        for (int ch = 0; ch < NCH; ch++) s[ch*SW +: SW] = SW'($urandom);
        return s;
    endfunction

    initial begin
        logic ben_f, fen_f, exp_b, exp_f, nb, nf;
        logic [SW-1:0] ew;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        #1;
        chk(dout == '0, "R1 lanes idle during reset", 32'(dout), 32'd0);
        @(negedge clk);
        rst   = 1'b0;
        ben_f = 1'b1;
        fen_f = 1'b1;
        for (int f = 0; f < NF; f++) begin
            for (int s = 0; s < FS; s++) begin
                #1;
                if (f == 0 && s == 0) begin
                    chk(fclk && bclk, "R1 clocks high at first slot",
                        {30'd0, fclk, bclk}, 32'd3);
                end
                exp_b = ben_f && (s % 2 == 0);
                exp_f = fen_f && (s < FS / 2);
                chk(bclk == exp_b, ben_f ? "R3 bit clock level" : "R9 bit clock held low",
                    32'(bclk), 32'(exp_b));
                chk(fclk == exp_f, fen_f ? "R4 frame clock level" : "R9 frame clock held low",
                    32'(fclk), 32'(exp_f));
                for (int ch = 0; ch < NCH; ch++) begin
                    if (s == 0) pad_bad[ch] = 1'b0;
                    if (s < 2) begin
                        if (dout[ch]) pad_bad[ch] = 1'b1;
                    end else begin
                        rx[ch][s-2] = dout[ch];
                    end
                end
                if (s == FS - 1) begin
                    for (int ch = 0; ch < NCH; ch++) begin
                        ew = exp_word(f, ch);
                        chk(!pad_bad[ch], "R2 pad slots zero", 32'(pad_bad[ch]), 32'd0);
                        chk(rx[ch] == ew, "R2/R5/R6/R7/R8 lane word", 32'(rx[ch]), 32'(ew));
                    end
                    smp_hist[f] = gen_sample(f);
                    fmt_hist[f] = (f < 6) ? f[0] : 1'($urandom);
                    smp = smp_hist[f];
                    fmt = fmt_hist[f];
                    nb = (f < 10) ? 1'b1 : ($urandom % 4 != 0);
                    nf = (f < 10) ? 1'b1 : ($urandom % 4 != 0);
                    ben   = nb;
                    fen   = nf;
                    ben_f = nb;
                    fen_f = nf;
                end else begin
                    // R8: these values must never reach a lane
                    smp = junk();
                    fmt = 1'($urandom);
                end
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule